// File: doc/BRIEF.md
# Coherent Phase Word Readout Port

This block presents a continuously changing 16-bit two's-complement phase value, taken from the output of a phase averager, to software through an 8-bit register read port. A configuration bit chooses which of two loop sources supplies the value. Software reads the low byte first and then the high byte.

The low-byte read does two things at the same clock edge. It returns the live low byte of the selected source, and it stores the live upper byte in a holding register. The high-byte read that follows returns the stored byte and never the live one. The two bytes therefore always come from one sample, even when the phase moves between the two accesses or the source selection changes between them.

Read data is registered. It appears one clock after the cycle in which the read strobe is sampled, and it holds its value until the next strobe.

Top module: `phase_snapshot_rd`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00 and the holding register is zero. A read of address 0x78 with no earlier read of 0x77 since reset returns 0x00.
- R2: A read strobe at address 0x77 sets `rd_data`, at the next rising edge, to bits [7:0] of the selected live phase value as it stood in the strobe cycle.
- R3: A read of 0x77 stores bits [15:8] of the selected live value in the holding register, in the same cycle it reads the low byte.
- R4: A read of 0x78 returns the held bits [15:8] and not the live upper byte. Joining that byte with the byte from 0x77 gives the signed 16-bit sample as it stood at the 0x77 read.
- R5: With `src_sel` = 0 the first-loop input `phase_a` is selected. With `src_sel` = 1 the second-loop input `phase_b` is selected.
- R6: A change of `src_sel` after a 0x77 read does not alter the byte a later 0x78 read returns.
- R7: The holding register changes only on a read of 0x77. Repeated 0x78 reads, reads of other addresses and idle cycles leave it unchanged.
- R8: A read of any address other than 0x77 or 0x78 returns 0x00.
- R9: While `rd_en` is low, `rd_data` holds its last value, whatever the phase inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 8 | Register address of the access |
| rd_data | output | 8 | Registered read data, valid the cycle after the strobe |
| phase_a | input | 16 | Averaged phase of the first loop, signed |
| phase_b | input | 16 | Averaged phase of the second loop, signed |
| src_sel | input | 1 | Source choice: 0 first loop, 1 second loop |

## Verification
The properties assume that `rd_en`, `rd_addr`, `src_sel` and both phase inputs are driven to known values that settle between clock edges. The high-byte property also assumes that a 0x78 read directly following a 0x77 read is the case in which the pair forms one coherent sample. The bench changes every input only on the falling edge, issues each strobe for exactly one cycle, and changes the phase inputs and the selection between the two reads of a pair. This keeps the stimulus inside those assumptions while still testing that the live value is not used.

// File: rtl/phase_snap_pkg.sv
package phase_snap_pkg;

  // Kind of access decoded from one read strobe
  typedef enum logic [1:0] {
    ACC_IDLE     = 2'd0,
    ACC_CAPTURE  = 2'd1,
    ACC_HELD     = 2'd2,
    ACC_UNMAPPED = 2'd3
  } acc_kind_e;

  localparam int unsigned PHASE_W_DEF   = 16;
  localparam int unsigned BUS_W_DEF     = 8;
  localparam int unsigned ADDR_W_DEF    = 8;
  localparam int unsigned BASE_ADDR_DEF = 32'h77;

endpackage

// File: rtl/phase_src_sel.sv
module phase_src_sel #(
  parameter int unsigned PHASE_W = 16
) (
  input  logic               src_sel,
  input  logic [PHASE_W-1:0] phase_a,
  input  logic [PHASE_W-1:0] phase_b,
  output logic [PHASE_W-1:0] live_phase
);

  always_comb begin
    live_phase = src_sel ? phase_b : phase_a;
  end

endmodule

// File: rtl/phase_addr_dec.sv
module phase_addr_dec
  import phase_snap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LANES     = 2,
  parameter int unsigned BASE_ADDR = 32'h77,
  localparam int unsigned LANE_IW  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output acc_kind_e         acc_kind,
  output logic [LANE_IW-1:0] acc_lane
);

  logic [LANES-1:0] lane_hit;

  for (genvar k = 0; k < LANES; k++) begin : g_hit
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + k);
    assign lane_hit[k] = (rd_addr == LANE_ADDR);
  end

  always_comb begin
    acc_lane = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_hit[k]) acc_lane = LANE_IW'(k);
    end
  end

  always_comb begin
    if (!rd_en)          acc_kind = ACC_IDLE;
    else if (lane_hit[0]) acc_kind = ACC_CAPTURE;
    else if (|lane_hit)   acc_kind = ACC_HELD;
    else                  acc_kind = ACC_UNMAPPED;
  end

endmodule

// File: rtl/phase_shadow_reg.sv
module phase_shadow_reg #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [HOLD_W-1:0] cap_din,
  output logic [HOLD_W-1:0] held_q
);

  always_ff @(posedge clk) begin
    if (rst)         held_q <= '0;
    else if (cap_en) held_q <= cap_din;
  end

  // R7
  shadow_only_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_en |=> $stable(held_q));

endmodule

// File: rtl/phase_rd_mux.sv
module phase_rd_mux
  import phase_snap_pkg::*;
#(
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned LANES   = 2,
  localparam int unsigned LANE_IW = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int unsigned HOLD_W  = BUS_W * (LANES - 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  acc_kind_e          acc_kind,
  input  logic [LANE_IW-1:0] acc_lane,
  input  logic [BUS_W-1:0]   live_low,
  input  logic [HOLD_W-1:0]  held_word,
  output logic [BUS_W-1:0]   rd_data
);

  logic [BUS_W-1:0] lane_byte [LANES];

  assign lane_byte[0] = live_low;
  for (genvar k = 1; k < LANES; k++) begin : g_lane
    assign lane_byte[k] = held_word[(k-1)*BUS_W +: BUS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (acc_kind)
        ACC_CAPTURE:  rd_data <= live_low;
        ACC_HELD:     rd_data <= lane_byte[acc_lane];
        ACC_UNMAPPED: rd_data <= '0;
        default:      rd_data <= rd_data;
      endcase
    end
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_IDLE) |=> $stable(rd_data));

endmodule

// File: rtl/phase_snapshot_rd.sv
module phase_snapshot_rd
  import phase_snap_pkg::*;
#(
  parameter int unsigned PHASE_W   = PHASE_W_DEF,
  parameter int unsigned BUS_W     = BUS_W_DEF,
  parameter int unsigned ADDR_W    = ADDR_W_DEF,
  parameter int unsigned BASE_ADDR = BASE_ADDR_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BUS_W-1:0]   rd_data,
  input  logic [PHASE_W-1:0] phase_a,
  input  logic [PHASE_W-1:0] phase_b,
  input  logic               src_sel
);

  localparam int unsigned LANES   = PHASE_W / BUS_W;
  localparam int unsigned LANE_IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned HOLD_W  = PHASE_W - BUS_W;
  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);
  localparam logic [ADDR_W:0]   TOP_ADDR = (ADDR_W+1)'(BASE_ADDR + LANES - 1);

  logic [PHASE_W-1:0] live_phase;
  acc_kind_e          acc_kind;
  logic [LANE_IW-1:0] acc_lane;
  logic [HOLD_W-1:0]  held_word;

  phase_src_sel #(.PHASE_W(PHASE_W)) src_i (
    .src_sel    (src_sel),
    .phase_a    (phase_a),
    .phase_b    (phase_b),
    .live_phase (live_phase)
  );

  phase_addr_dec #(.ADDR_W(ADDR_W), .LANES(LANES), .BASE_ADDR(BASE_ADDR)) dec_i (
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .acc_kind (acc_kind),
    .acc_lane (acc_lane)
  );

  phase_shadow_reg #(.HOLD_W(HOLD_W)) shadow_i (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (acc_kind == ACC_CAPTURE),
    .cap_din (live_phase[PHASE_W-1:BUS_W]),
    .held_q  (held_word)
  );

  phase_rd_mux #(.BUS_W(BUS_W), .LANES(LANES)) mux_i (
    .clk       (clk),
    .rst       (rst),
    .acc_kind  (acc_kind),
    .acc_lane  (acc_lane),
    .live_low  (live_phase[BUS_W-1:0]),
    .held_word (held_word),
    .rd_data   (rd_data)
  );

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == '0 && held_word == '0));

  // R2 R5
  low_live_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == LO_ADDR) |=>
      rd_data == $past(src_sel ? phase_b[BUS_W-1:0] : phase_a[BUS_W-1:0]));

  // R4 R6
  high_coherent_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == HI_ADDR && $past(rd_en && rd_addr == LO_ADDR)) |=>
      rd_data == $past(src_sel ? phase_b[2*BUS_W-1:BUS_W] : phase_a[2*BUS_W-1:BUS_W], 2));

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr < LO_ADDR || {1'b0, rd_addr} > TOP_ADDR)) |=> rd_data == '0);

endmodule

// File: tb/phase_snapshot_rd_tb.sv
module phase_snapshot_rd_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] phase_a = '0;
  logic [15:0] phase_b = '0;
  logic        src_sel = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_snapshot_rd dut_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .phase_a(phase_a), .phase_b(phase_b), .src_sel(src_sel)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] addr, output logic [7:0] val);
    @(negedge clk);
    rd_en = 1'b1;
    rd_addr = addr;
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
  endtask

  task automatic set_inputs(input logic [15:0] a, input logic [15:0] b, input logic s);
    @(negedge clk);
    phase_a = a;
    phase_b = b;
    src_sel = s;
  endtask

  function automatic logic [15:0] pattern(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'h00FF;
      5: return 16'hFF00;
      default: return 16'(i * 16'h0B3D + (i % 3) * 16'h8001);
    endcase
  endfunction

  initial begin
    logic [7:0] lo, hi, hi2;
    logic [15:0] sel_val;
    logic signed [15:0] joined;
    logic signed [15:0] ref_val;
    repeat (3) @(negedge clk);
    check("R1 reset rd_data", {8'h00, rd_data}, 16'h0000);
    rst = 1'b0;
    set_inputs(16'h1234, 16'hABCD, 1'b0);
    do_read(8'h78, hi);
    check("R1 high before low", {8'h00, hi}, 16'h0000);

    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 48; i++) begin
        logic [15:0] va, vb;
        va = pattern(i);
        vb = ~pattern(i) ^ 16'h5A5A;
        set_inputs(va, vb, s[0]);
        sel_val = s[0] ? vb : va;
        do_read(8'h77, lo);
        check("R2 R5 low byte", {8'h00, lo}, {8'h00, sel_val[7:0]});
        set_inputs(va ^ 16'hFFFF, vb + 16'h0101, s[0]);
        do_read(8'h78, hi);
        check("R3 R4 held high", {8'h00, hi}, {8'h00, sel_val[15:8]});
        joined = {hi, lo};
        ref_val = sel_val;
        checks++;
        if (joined != ref_val) begin
          failures++;
          $display("FAIL R4 signed join actual=%0d expected=%0d", joined, ref_val);
        end
      end
    end

    set_inputs(16'hC3A5, 16'h1E2F, 1'b0);
    do_read(8'h77, lo);
    set_inputs(16'hC3A5, 16'h1E2F, 1'b1);
    do_read(8'h78, hi);
    check("R6 select flip", {8'h00, hi}, 16'h00C3);

    set_inputs(16'h4455, 16'h6677, 1'b0);
    do_read(8'h78, hi2);
    check("R7 repeat high read", {8'h00, hi2}, 16'h00C3);

    for (int u = 0; u < 4; u++) begin
      logic [7:0] ua;
      ua = (u == 0) ? 8'h76 : (u == 1) ? 8'h79 : (u == 2) ? 8'h00 : 8'hFF;
      do_read(ua, lo);
      check("R8 unmapped read", {8'h00, lo}, 16'h0000);
    end
    do_read(8'h78, hi);
    check("R7 held after unmapped", {8'h00, hi}, 16'h00C3);

    do_read(8'h78, hi);
    set_inputs(16'h9999, 16'h8888, 1'b1);
    repeat (4) @(negedge clk);
    check("R9 idle hold", {8'h00, rd_data}, 16'h00C3);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset again", {8'h00, rd_data}, 16'h0000);
    do_read(8'h78, hi);
    check("R1 held cleared", {8'h00, hi}, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule